// File: doc/BRIEF.md
# Receive Line Decoder with Selectable Output Format

This block is the digital back end of a T1/E1 receive path. It takes the positive and negative mark rails recovered by the analog front end, together with the recovered bit clock, and presents them in one of three formats. In bipolar format the rails pass through untouched so that an external framer can do its own line decoding. In unipolar format the block removes the line code (AMI, B8ZS or HDB3) and delivers NRZ data on the positive output, with a one-bit-time flag on the negative output for every bipolar violation that is not part of a recognised substitution. In RZ format the rails are delivered as return-to-zero pulses that occupy the high half of each bit period.

Unipolar decoding runs through a shift pipeline of recovered symbols so that a complete substitution word is visible before its first bit leaves. A polarity reference, updated by every mark that leaves the pipeline, decides both whether a window is a legal substitution and whether a lone mark is a violation. A separate edge-select input chooses whether the outputs change on the falling edge, and so are valid at the rising edge, or change on the rising edge and are valid at the falling edge.

Top module: `rx_line_decoder`

## Requirements
- R1: While rst_ni is low, pos_o and neg_o are 0 and the pipeline is cleared; the polarity reference is set to negative.
- R2: In bipolar format, pos_o and neg_o repeat the pos_i and neg_i values captured at the previous rising edge, including the case where both rails are high.
- R3: fmt_i selects the format: 0 bipolar, 1 unipolar, 2 RZ; the value 3 behaves as bipolar.
- R4: In unipolar format a mark on either rail leaves as a one on pos_o exactly PIPE_DEPTH (default 8) clock cycles after the edge that captured it; both rails high count as a positive mark.
- R5: In unipolar format, a mark not removed by a substitution whose polarity equals the polarity reference raises neg_o for that one bit time; after reset the reference is negative, so a first negative mark is flagged.
- R6: With code_i = 1 (B8ZS), a received 000VB0VB word, where V has the polarity of the previous mark and B the opposite, leaves as eight zeros with no flag; the reference then equals the polarity of that previous mark.
- R7: With code_i = 2 (HDB3), a received 000V word with V equal to the reference, or B00V with B opposite the reference and V equal to B, leaves as four zeros with no flag; the reference then equals the polarity of V.
- R8: code_i selects AMI (0 or 3), B8ZS (1) or HDB3 (2); under AMI a substitution word is decoded mark by mark and its violations are flagged; code_i has no effect in bipolar format.
- R9: With edge_sel_i = 1 the outputs change just after the rising edge; with edge_sel_i = 0 they change just after the falling edge and hold across the rising edge.
- R10: In RZ format the outputs carry the bipolar-format values while clk_i is high and are 0 while clk_i is low.
- R11: Under B8ZS or HDB3, marks that do not belong to a recognised substitution are still decoded as ones and violations among them are flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 2 | Output format select |
| code_i | input | 2 | Line code select for unipolar format |
| edge_sel_i | input | 1 | 1: outputs change on rising edge; 0: on falling edge |
| pos_i | input | 1 | Recovered positive mark rail |
| neg_i | input | 1 | Recovered negative mark rail |
| pos_o | output | 1 | Positive rail, NRZ data in unipolar format |
| neg_o | output | 1 | Negative rail, violation flag in unipolar format |

## Verification
The bench builds the block with PIPE_DEPTH at its default of 8, which is the smallest depth that holds a whole B8ZS word; that makes the eight-bit decode latency and the substitution window line up exactly, so any off-by-one in the window taps shows as a misplaced zero or a stray flag. Random mark streams mix alternating marks, deliberate violations, double-rail marks and inserted substitution words under every line code, so the polarity reference is exercised both before and after substitutions. Directed streams cover the first mark after reset, a B8ZS word decoded under AMI, and both edge-select settings in bipolar and RZ format.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam logic [1:0] FMT_BIPOLAR  = 2'd0;
  localparam logic [1:0] FMT_UNIPOLAR = 2'd1;
  localparam logic [1:0] FMT_RZ       = 2'd2;

  localparam logic [1:0] CODE_AMI  = 2'd0;
  localparam logic [1:0] CODE_B8ZS = 2'd1;
  localparam logic [1:0] CODE_HDB3 = 2'd2;

  // substitution search window, sized by the longest code word
  localparam int unsigned WIN = 8;

  typedef struct packed {
    logic p;  // positive mark
    logic n;  // negative mark
    logic k;  // removed by a substitution
  } sym_t;
endpackage

// File: rtl/rxd_sub_detect.sv
module rxd_sub_detect
  import rxd_pkg::*;
(
  input  sym_t             win_i [WIN],  // index 0 is the oldest symbol
  input  logic             last_neg_i,
  input  logic [1:0]       code_i,
  output logic [WIN-1:0]   kill_o
);
  logic [WIN-1:0] mk, zr, ng;

  for (genvar j = 0; j < WIN; j++) begin : g_cls
    assign mk[j] = (win_i[j].p | win_i[j].n) & ~win_i[j].k;
    assign zr[j] = ~win_i[j].p & ~win_i[j].n;
    assign ng[j] = win_i[j].n & ~win_i[j].p;
  end

  logic use_b8, use_h3;
  logic hit_b8, hit_h0, hit_hb;

  assign use_b8 = (code_i == CODE_B8ZS);
  assign use_h3 = (code_i == CODE_HDB3);

  always_comb begin
    // 000 V B 0 V B
    hit_b8 = use_b8 & zr[0] & zr[1] & zr[2]
           & mk[3] & (ng[3] == last_neg_i)
           & mk[4] & (ng[4] != last_neg_i)
           & zr[5]
           & mk[6] & (ng[6] != last_neg_i)
           & mk[7] & (ng[7] == last_neg_i);
    // 000 V
    hit_h0 = use_h3 & zr[0] & zr[1] & zr[2]
           & mk[3] & (ng[3] == last_neg_i);
    // B 00 V
    hit_hb = use_h3 & mk[0] & (ng[0] != last_neg_i)
           & zr[1] & zr[2]
           & mk[3] & (ng[3] == ng[0]);

    kill_o = '0;
    if (hit_b8) begin
      kill_o[3] = 1'b1;
      kill_o[4] = 1'b1;
      kill_o[6] = 1'b1;
      kill_o[7] = 1'b1;
    end
    if (hit_h0) kill_o[3] = 1'b1;
    if (hit_hb) begin
      kill_o[0] = 1'b1;
      kill_o[3] = 1'b1;
    end
  end
endmodule

// File: rtl/rxd_unipolar.sv
module rxd_unipolar
  import rxd_pkg::*;
#(
  parameter int unsigned DEPTH = 8  // must be at least WIN
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pos_i,
  input  logic       neg_i,
  input  logic [1:0] code_i,
  output logic       data_o,
  output logic       viol_o
);
  localparam int unsigned TOP = DEPTH - 1;

  sym_t             stg      [DEPTH];
  sym_t             win      [WIN];
  logic [WIN-1:0]   win_kill;
  logic [DEPTH-1:0] stg_kill;
  logic             last_neg;

  // window index j looks at stage TOP-j
  for (genvar j = 0; j < WIN; j++) begin : g_win
    assign win[j] = stg[TOP-j];
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_skill
    if (TOP - s < WIN) begin : g_in
      assign stg_kill[s] = win_kill[TOP-s];
    end else begin : g_out
      assign stg_kill[s] = 1'b0;
    end
  end

  rxd_sub_detect u_detect (
    .win_i      (win),
    .last_neg_i (last_neg),
    .code_i     (code_i),
    .kill_o     (win_kill)
  );

  logic top_raw, top_neg;
  assign top_raw = stg[TOP].p | stg[TOP].n;
  assign top_neg = stg[TOP].n & ~stg[TOP].p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
      last_neg <= 1'b1;
    end else begin
      stg[0] <= '{p: pos_i, n: neg_i, k: 1'b0};
      for (int i = 1; i < DEPTH; i++) begin
        stg[i]   <= stg[i-1];
        stg[i].k <= stg[i-1].k | stg_kill[i-1];
      end
      // reference follows every mark leaving, substituted or not
      if (top_raw) last_neg <= top_neg;
    end
  end

  assign data_o = top_raw & ~stg[TOP].k & ~stg_kill[TOP];
  assign viol_o = data_o & (top_neg == last_neg);
endmodule

// File: rtl/rxd_out_stage.sv
module rxd_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rz_i,
  input  logic edge_sel_i,
  input  logic pos_i,
  input  logic neg_i,
  output logic pos_o,
  output logic neg_o
);
  logic fall_pos, fall_neg;
  logic sel_pos, sel_neg;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fall_pos <= 1'b0;
      fall_neg <= 1'b0;
    end else begin
      fall_pos <= pos_i;
      fall_neg <= neg_i;
    end
  end

  assign sel_pos = edge_sel_i ? pos_i : fall_pos;
  assign sel_neg = edge_sel_i ? neg_i : fall_neg;

  // RZ: pulse only in the high half of the bit
  assign pos_o = sel_pos & (~rz_i | clk_i);
  assign neg_o = sel_neg & (~rz_i | clk_i);
endmodule

// File: rtl/rx_line_decoder.sv
module rx_line_decoder
  import rxd_pkg::*;
#(
  parameter int unsigned PIPE_DEPTH = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] fmt_i,
  input  logic [1:0] code_i,
  input  logic       edge_sel_i,
  input  logic       pos_i,
  input  logic       neg_i,
  output logic       pos_o,
  output logic       neg_o
);
  logic uni_data, uni_viol;
  logic core_pos, core_neg;
  logic is_uni, is_rz;

  assign is_uni = (fmt_i == FMT_UNIPOLAR);
  assign is_rz  = (fmt_i == FMT_RZ);

  rxd_unipolar #(.DEPTH(PIPE_DEPTH)) u_uni (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pos_i  (pos_i),
    .neg_i  (neg_i),
    .code_i (code_i),
    .data_o (uni_data),
    .viol_o (uni_viol)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      core_pos <= 1'b0;
      core_neg <= 1'b0;
    end else if (is_uni) begin
      core_pos <= uni_data;
      core_neg <= uni_viol;
    end else begin
      core_pos <= pos_i;
      core_neg <= neg_i;
    end
  end

  rxd_out_stage u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rz_i       (is_rz),
    .edge_sel_i (edge_sel_i),
    .pos_i      (core_pos),
    .neg_i      (core_neg),
    .pos_o      (pos_o),
    .neg_o      (neg_o)
  );
endmodule

// File: rtl/rx_line_decoder_chk.sv
module rx_line_decoder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] fmt_i,
  input logic       edge_sel_i,
  input logic       pos_i,
  input logic       neg_i,
  input logic       pos_o,
  input logic       neg_o,
  input logic       core_pos,
  input logic       core_neg
);
  logic bip_now;
  assign bip_now = (fmt_i == 2'd0) || (fmt_i == 2'd3);

  // R2 R3
  bipolar_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bip_now && $past(bip_now) && edge_sel_i)
      |-> (pos_o == $past(pos_i) && neg_o == $past(neg_i)));

  // R5
  flag_needs_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i == 2'd1 && core_neg) |-> core_pos);

  // R9
  fall_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i != 2'd2 && !edge_sel_i) |-> (pos_o == core_pos && neg_o == core_neg));

  // R10
  rz_low_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i == 2'd2) |-> (!pos_o && !neg_o));
endmodule

bind rx_line_decoder rx_line_decoder_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fmt_i      (fmt_i),
  .edge_sel_i (edge_sel_i),
  .pos_i      (pos_i),
  .neg_i      (neg_i),
  .pos_o      (pos_o),
  .neg_o      (neg_o),
  .core_pos   (core_pos),
  .core_neg   (core_neg)
);

// File: tb/tb_rx_line_decoder.sv
`timescale 1ns/1ps
module tb_rx_line_decoder;
  localparam int N   = 400;
  localparam int LAT = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [1:0] fmt_i;
  logic [1:0] code_i;
  logic       edge_sel_i;
  logic       pos_i, neg_i;
  logic       pos_o, neg_o;

  int errs = 0;
  int chks = 0;

  logic sp [N];
  logic sn [N];
  logic ed [N];
  logic ev [N];

  always #2.5 clk_i = ~clk_i;

  rx_line_decoder #(.PIPE_DEPTH(LAT)) dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fmt_i      (fmt_i),
    .code_i     (code_i),
    .edge_sel_i (edge_sel_i),
    .pos_i      (pos_i),
    .neg_i      (neg_i),
    .pos_o      (pos_o),
    .neg_o      (neg_o)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    chks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    pos_i  = 1'b0;
    neg_i  = 1'b0;
    repeat (3) @(negedge clk_i);
    #1 rst_ni = 1'b1;
  endtask

  task automatic clear_stream();
    for (int i = 0; i < N; i++) begin
      sp[i] = 1'b0;
      sn[i] = 1'b0;
    end
  endtask

  task automatic put(input int i, input logic is_neg);
    if (is_neg) sn[i] = 1'b1; else sp[i] = 1'b1;
  endtask

  // random stream: first and last stretches stay empty
  task automatic gen(input logic [1:0] code, input int len);
    logic lp;
    int i;
    lp = 1'b1;
    clear_stream();
    i = 8;
    while (i < len - 16) begin
      int r;
      r = $urandom_range(99);
      if (r < 45) i++;
      else if (r < 80) begin put(i, ~lp); lp = ~lp; i++; end
      else if (r < 87) begin put(i, lp); i++; end
      else if (r < 91) begin sp[i] = 1'b1; sn[i] = 1'b1; lp = 1'b0; i++; end
      else if (code == 2'd1) begin
        put(i+3, lp); put(i+4, ~lp); put(i+6, ~lp); put(i+7, lp);
        i += 8;
      end else if (code == 2'd2) begin
        if ($urandom_range(1) == 1) begin
          put(i+3, lp);
        end else begin
          put(i, ~lp); put(i+3, ~lp); lp = ~lp;
        end
        i += 4;
      end else i++;
    end
  endtask

  function automatic logic mk(input int i);
    return sp[i] | sn[i];
  endfunction
  function automatic logic ngv(input int i);
    return sn[i] & ~sp[i];
  endfunction
  function automatic logic zr(input int i);
    return ~sp[i] & ~sn[i];
  endfunction

  // expected unipolar output from the requirements
  task automatic model(input logic [1:0] code, input int len);
    logic p;
    int i;
    p = 1'b1;
    i = 0;
    while (i < len) begin
      if (code == 2'd1 && i + 7 < len && zr(i) && zr(i+1) && zr(i+2)
          && mk(i+3) && ngv(i+3) == p && mk(i+4) && ngv(i+4) != p && zr(i+5)
          && mk(i+6) && ngv(i+6) != p && mk(i+7) && ngv(i+7) == p) begin
        for (int j = 0; j < 8; j++) begin ed[i+j] = 1'b0; ev[i+j] = 1'b0; end
        i += 8;
      end else if (code == 2'd2 && i + 3 < len && zr(i) && zr(i+1) && zr(i+2)
                   && mk(i+3) && ngv(i+3) == p) begin
        for (int j = 0; j < 4; j++) begin ed[i+j] = 1'b0; ev[i+j] = 1'b0; end
        p = ngv(i+3);
        i += 4;
      end else if (code == 2'd2 && i + 3 < len && mk(i) && ngv(i) != p
                   && zr(i+1) && zr(i+2) && mk(i+3) && ngv(i+3) == ngv(i)) begin
        for (int j = 0; j < 4; j++) begin ed[i+j] = 1'b0; ev[i+j] = 1'b0; end
        p = ngv(i+3);
        i += 4;
      end else begin
        ed[i] = mk(i);
        ev[i] = mk(i) && (ngv(i) == p);
        if (mk(i)) p = ngv(i);
        i++;
      end
    end
  endtask

  task automatic run_uni(input logic [1:0] code, input int len, input string rd, input string rv);
    do_reset();
    fmt_i = 2'd1; code_i = code; edge_sel_i = 1'b1;
    model(code, len);
    for (int t = 0; t < len + LAT; t++) begin
      pos_i = (t < len) ? sp[t] : 1'b0;
      neg_i = (t < len) ? sn[t] : 1'b0;
      @(posedge clk_i);
      @(negedge clk_i);
      #1;
      if (t >= LAT) begin
        check(rd, {1'b0, pos_o}, {1'b0, ed[t-LAT]});
        check(rv, {1'b0, neg_o}, {1'b0, ev[t-LAT]});
      end
    end
  endtask

  task automatic run_bip(input logic [1:0] fmt, input int len, input string req);
    do_reset();
    fmt_i = fmt; edge_sel_i = 1'b1;
    for (int t = 0; t < len; t++) begin
      logic a, b;
      a = 1'($urandom_range(1));
      b = 1'($urandom_range(1));
      code_i = 2'($urandom_range(3));
      pos_i = a; neg_i = b;
      @(posedge clk_i);
      @(negedge clk_i);
      #1 check(req, {pos_o, neg_o}, {a, b});
    end
  endtask

  // edge select and RZ: sample after each edge
  task automatic run_edge(input logic [1:0] fmt, input logic sel, input int len,
                          input string req);
    logic pa, pb;
    do_reset();
    fmt_i = fmt; edge_sel_i = sel; code_i = 2'd0;
    pa = 1'b0; pb = 1'b0;
    for (int t = 0; t < len; t++) begin
      logic a, b;
      logic [1:0] hi_exp, lo_exp;
      a = 1'($urandom_range(1));
      b = 1'($urandom_range(1));
      pos_i = a; neg_i = b;
      @(posedge clk_i);
      #1;
      hi_exp = sel ? {a, b} : {pa, pb};
      check(req, {pos_o, neg_o}, hi_exp);
      @(negedge clk_i);
      #1;
      lo_exp = (fmt == 2'd2) ? 2'b00 : {a, b};
      check(req, {pos_o, neg_o}, lo_exp);
      pa = a; pb = b;
    end
  endtask

  initial begin
    #900000;
    errs++;
    chks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    fmt_i = 2'd0; code_i = 2'd0; edge_sel_i = 1'b1;

    // R1: outputs held low while reset is active
    rst_ni = 1'b0;
    pos_i = 1'b1; neg_i = 1'b1;
    repeat (3) @(negedge clk_i);
    #1 check("R1", {pos_o, neg_o}, 2'b00);
    fmt_i = 2'd2;
    @(posedge clk_i); #1 check("R1", {pos_o, neg_o}, 2'b00);

    // R2 R8: bipolar pass-through, code_i randomised
    run_bip(2'd0, 120, "R2");
    // R3: format value 3 behaves as bipolar
    run_bip(2'd3, 60, "R3");

    // R4 R5: AMI random
    gen(2'd0, N);
    run_uni(2'd0, N, "R4", "R5");

    // R5: first negative mark after reset is flagged, then alternation
    clear_stream();
    put(8, 1'b1); put(9, 1'b0); put(10, 1'b1); put(11, 1'b1);
    sp[13] = 1'b1; sn[13] = 1'b1; put(14, 1'b0);
    run_uni(2'd0, 40, "R4", "R5");

    // R6: directed B8ZS word after a positive mark
    clear_stream();
    put(8, 1'b0);
    put(12, 1'b0); put(13, 1'b1); put(15, 1'b1); put(16, 1'b0);
    put(18, 1'b1); put(20, 1'b1);
    run_uni(2'd1, 40, "R6", "R6");
    // R8: same word under AMI (code 3) is decoded mark by mark
    run_uni(2'd3, 40, "R8", "R8");

    // R6 R11: B8ZS random
    gen(2'd1, N);
    run_uni(2'd1, N, "R6", "R11");

    // R7: directed 000V and B00V
    clear_stream();
    put(8, 1'b0);
    put(12, 1'b0);
    put(13, 1'b1); put(16, 1'b1);
    put(18, 1'b0); put(19, 1'b0);
    run_uni(2'd2, 40, "R7", "R7");

    // R7 R11: HDB3 random
    gen(2'd2, N);
    run_uni(2'd2, N, "R7", "R11");
    // R8: HDB3 stream under AMI
    run_uni(2'd0, N, "R8", "R8");

    // R9: both edge settings in bipolar format
    run_edge(2'd0, 1'b1, 40, "R9");
    run_edge(2'd0, 1'b0, 40, "R9");
    // R10: RZ pulses in the high half only
    run_edge(2'd2, 1'b1, 40, "R10");
    run_edge(2'd2, 1'b0, 40, "R10");

    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule